// File: doc/BRIEF.md
# Multiprocessor Interrupt Register Block

This block is the interrupt hub of a system with up to four CPUs, reached through a simple register port. It keeps one 64-bit device mask per CPU. It samples a shared 64-bit raw device request vector every cycle and presents each CPU's masked request, which is its mask ANDed with the raw vector. A CPU's device interrupt line is high whenever that masked request is non-zero.

The block also holds two pending flags per CPU: an inter-processor interrupt flag and an interval-timer flag. Each flag drives its own output line. A timer flag is set by a per-CPU tick input.

Software changes the flags in two ways. One way is a control register, where a single 64-bit write carries separate CPU bitmaps to post IPIs, clear IPIs and clear timer flags, plus a bit that acknowledges a non-existent-memory error. The other way is a set of dedicated clear and post registers. Every accepted request returns a response one cycle later, with read data and an error flag.

Top module: `cpu_intr_regs`

## Requirements
- R1: After reset all masks, IPI flags and timer flags are zero, `dev_irq_o`, `ipi_o` and `tmr_o` are zero, and `rsp_valid_o` is low.
- R2: Register offsets are word indices. Offset 8+c reads back CPU c's mask. Offset 12+c reads CPU c's masked request, which is that mask ANDed with the raw vector captured on the previous clock edge. Offset 16 reads the captured raw vector.
- R3: `dev_irq_o[c]` is high exactly when CPU c's masked request is non-zero. It reflects a mask write from the edge that accepts the write, and a change on `dev_req_i` from the following edge.
- R4: A full write to the control register (offset 1) sets the IPI flag of every CPU c for which data bit 12+c is set.
- R5: In a control write, data bit 8+c clears CPU c's IPI flag and data bit 4+c clears CPU c's timer flag. A clear beats a post in the same write, and it also beats a timer tick in the same cycle.
- R6: A control write with only bit 28 set is accepted without error. A control write in which bits 15:4 are all zero and bit 28 is clear returns an error and changes nothing.
- R7: A read of the control register returns `req_cpu_i` in bits 1:0, with all other bits zero.
- R8: A write to offset 17 clears IPI flags and a write to offset 18 clears timer flags, for each CPU whose data bit c is set. A write to offset 19 sets the IPI flag of each CPU whose data bit c is set. Reads of offsets 17 and 18 return the IPI and timer pending vectors in bits 3:0.
- R9: Reads of offset 0 and of offsets 2 to 5 return zero without error.
- R10: A write with `req_full_i` low returns an error and changes no state.
- R11: An access to offset 6, 7 or 20 to 31 returns an error and read data zero. So do a write to offset 0, 2-5 or 12-16 and a read of offset 19. None of these changes any state.
- R12: `req_ready_o` is always high. Each request with `req_valid_i` high gives `rsp_valid_o` high on the next cycle, and there is no response without a request.
- R13: A high bit c on `tmr_tick_i` sets CPU c's timer flag, and `tmr_o[c]` follows that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Always high |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_full_i | input | 1 | Access is a full 64-bit word |
| req_addr_i | input | 5 | Register word offset |
| req_wdata_i | input | 64 | Write data |
| req_cpu_i | input | 2 | Identifier of the requesting CPU |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_rdata_o | output | 64 | Read data |
| rsp_err_o | output | 1 | Unsupported or malformed access |
| dev_req_i | input | 64 | Shared raw device request vector |
| tmr_tick_i | input | 4 | Per-CPU interval-timer event |
| dev_irq_o | output | 4 | Per-CPU device interrupt |
| ipi_o | output | 4 | Per-CPU inter-processor interrupt |
| tmr_o | output | 4 | Per-CPU timer interrupt |

## Verification
The masking path is driven with a raw vector whose set bits fall inside one CPU's mask and outside another's. It is then driven with a raw vector that moves the overlap, and then with a mask cleared back to zero. Together these show that each CPU ANDs with its own mask, and they show the one-cycle latency from the raw input against the same-edge response to a mask write. The control register is driven with post-only data, post and clear on the same CPU, error-acknowledge alone, and all-zero data. These separate the lane positions, the clear-over-post priority and the unsupported-write error. Timer clears that land in the same cycle as a tick, writes that are not full width, and accesses to reserved offsets show that rejected requests leave the flags and masks untouched.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int DEF_N_CPU  = 4;
  localparam int DEF_DATA_W = 64;
  localparam int DEF_ADDR_W = 5;

  // register word offsets
  localparam int OFF_STAT   = 0;
  localparam int OFF_CTRL   = 1;
  localparam int OFF_AAR    = 2;
  localparam int N_AAR      = 4;
  localparam int OFF_MASK   = 8;
  localparam int OFF_MASKED = 12;
  localparam int OFF_RAW    = 16;
  localparam int OFF_IPI    = 17;
  localparam int OFF_TMR    = 18;
  localparam int OFF_IPIQ   = 19;

  // control-register lane positions
  localparam int LANE_TCLR  = 4;
  localparam int LANE_ICLR  = 8;
  localparam int LANE_POST  = 12;
  localparam int BIT_NXM    = 28;

  typedef enum logic [3:0] {
    K_ZERO, K_CTRL, K_MASK, K_MASKED, K_RAW, K_IPI, K_TMR, K_IPIQ, K_BAD
  } kind_e;
endpackage

// File: rtl/cir_decode.sv
module cir_decode
  import cir_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int N_CPU  = DEF_N_CPU,
  parameter int CPU_W  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output kind_e             kind_o,
  output logic [CPU_W-1:0]  idx_o
);
  int a;

  always_comb begin
    a      = int'(addr_i);
    kind_o = K_BAD;
    idx_o  = '0;
    if (a == OFF_STAT) kind_o = K_ZERO;
    else if (a == OFF_CTRL) kind_o = K_CTRL;
    else if (a >= OFF_AAR && a < OFF_AAR + N_AAR) kind_o = K_ZERO;
    else if (a >= OFF_MASK && a < OFF_MASK + N_CPU) begin
      kind_o = K_MASK;
      idx_o  = CPU_W'(a - OFF_MASK);
    end else if (a >= OFF_MASKED && a < OFF_MASKED + N_CPU) begin
      kind_o = K_MASKED;
      idx_o  = CPU_W'(a - OFF_MASKED);
    end else if (a == OFF_RAW) kind_o = K_RAW;
    else if (a == OFF_IPI) kind_o = K_IPI;
    else if (a == OFF_TMR) kind_o = K_TMR;
    else if (a == OFF_IPIQ) kind_o = K_IPIQ;
  end
endmodule

// File: rtl/cir_mask_bank.sv
module cir_mask_bank #(
  parameter int N_CPU  = 4,
  parameter int DATA_W = 64,
  parameter int CPU_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [CPU_W-1:0]              idx_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [DATA_W-1:0]             raw_i,
  output logic [DATA_W-1:0]             raw_o,
  output logic [N_CPU-1:0][DATA_W-1:0]  mask_o,
  output logic [N_CPU-1:0][DATA_W-1:0]  masked_o,
  output logic [N_CPU-1:0]              irq_o
);
  logic [DATA_W-1:0] raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_i;
  end
  assign raw_o = raw_q;

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [DATA_W-1:0] mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mask_q <= '0;
      else if (we_i && idx_i == CPU_W'(c))    mask_q <= wdata_i;
    end
    assign mask_o[c]   = mask_q;
    assign masked_o[c] = mask_q & raw_q;
    assign irq_o[c]    = |masked_o[c];
  end
endmodule

// File: rtl/cir_flag_bank.sv
module cir_flag_bank #(
  parameter int N_CPU = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] set_i,
  input  logic [N_CPU-1:0] clr_i,
  output logic [N_CPU-1:0] q_o
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_flag
    logic q;
    // clear wins over set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[c]) q <= 1'b0;
      else if (set_i[c]) q <= 1'b1;
    end
    assign q_o[c] = q;
  end
endmodule

// File: rtl/cpu_intr_regs.sv
module cpu_intr_regs
  import cir_pkg::*;
#(
  parameter int N_CPU  = DEF_N_CPU,
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic              req_full_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [CPU_W-1:0]  req_cpu_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  input  logic [DATA_W-1:0] dev_req_i,
  input  logic [N_CPU-1:0]  tmr_tick_i,
  output logic [N_CPU-1:0]  dev_irq_o,
  output logic [N_CPU-1:0]  ipi_o,
  output logic [N_CPU-1:0]  tmr_o
);
  kind_e                         kind;
  logic [CPU_W-1:0]              idx;
  logic                          wr, rd, err, wr_ok, ctrl_any;
  logic [N_CPU-1:0]              post, iclr, tclr, low;
  logic                          nxm;
  logic [N_CPU-1:0]              ipi_set, ipi_clr, tmr_clr;
  logic [DATA_W-1:0]             raw_w, rdata_d;
  logic [N_CPU-1:0][DATA_W-1:0]  mask_w, masked_w;
  logic                          rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0]             rsp_rdata_q;

  assign req_ready_o = 1'b1;

  cir_decode #(.ADDR_W(ADDR_W), .N_CPU(N_CPU), .CPU_W(CPU_W)) u_dec (
    .addr_i (req_addr_i),
    .kind_o (kind),
    .idx_o  (idx)
  );

  assign wr   = req_valid_i & req_write_i;
  assign rd   = req_valid_i & ~req_write_i;
  assign post = req_wdata_i[LANE_POST +: N_CPU];
  assign iclr = req_wdata_i[LANE_ICLR +: N_CPU];
  assign tclr = req_wdata_i[LANE_TCLR +: N_CPU];
  assign low  = req_wdata_i[N_CPU-1:0];
  assign nxm  = req_wdata_i[BIT_NXM];
  assign ctrl_any = (|post) | (|iclr) | (|tclr) | nxm;

  always_comb begin
    unique case (kind)
      K_BAD:                 err = 1'b1;
      K_ZERO, K_MASKED, K_RAW: err = req_write_i;
      K_IPIQ:                err = ~req_write_i;
      K_CTRL:                err = req_write_i & ~ctrl_any;
      default:               err = 1'b0;
    endcase
    if (req_write_i && !req_full_i) err = 1'b1;
  end

  assign wr_ok = wr & ~err;

  always_comb begin
    ipi_set = '0;
    ipi_clr = '0;
    tmr_clr = '0;
    if (wr_ok) begin
      case (kind)
        K_CTRL: begin
          ipi_set = post;
          ipi_clr = iclr;
          tmr_clr = tclr;
        end
        K_IPIQ:  ipi_set = low;
        K_IPI:   ipi_clr = low;
        K_TMR:   tmr_clr = low;
        default: ;
      endcase
    end
  end

  cir_mask_bank #(.N_CPU(N_CPU), .DATA_W(DATA_W), .CPU_W(CPU_W)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_ok && kind == K_MASK),
    .idx_i    (idx),
    .wdata_i  (req_wdata_i),
    .raw_i    (dev_req_i),
    .raw_o    (raw_w),
    .mask_o   (mask_w),
    .masked_o (masked_w),
    .irq_o    (dev_irq_o)
  );

  cir_flag_bank #(.N_CPU(N_CPU)) u_ipi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ipi_set),
    .clr_i  (ipi_clr),
    .q_o    (ipi_o)
  );

  cir_flag_bank #(.N_CPU(N_CPU)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (tmr_tick_i),
    .clr_i  (tmr_clr),
    .q_o    (tmr_o)
  );

  always_comb begin
    rdata_d = '0;
    if (rd && !err) begin
      case (kind)
        K_CTRL:   rdata_d = DATA_W'(req_cpu_i);
        K_MASK:   rdata_d = mask_w[idx];
        K_MASKED: rdata_d = masked_w[idx];
        K_RAW:    rdata_d = raw_w;
        K_IPI:    rdata_d = DATA_W'(ipi_o);
        K_TMR:    rdata_d = DATA_W'(tmr_o);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_err_q   <= req_valid_i & err;
      rsp_rdata_q <= rdata_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/cir_chk.sv
module cir_chk
  import cir_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int DATA_W = 64,
  parameter int ADDR_W = 5
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_valid_i,
  input logic                         req_write_i,
  input logic                         req_full_i,
  input logic [ADDR_W-1:0]            req_addr_i,
  input logic [N_CPU-1:0]             post_i,
  input logic [N_CPU-1:0]             iclr_i,
  input logic [N_CPU-1:0]             tclr_i,
  input logic                         nxm_i,
  input logic                         rsp_valid_o,
  input logic                         rsp_err_o,
  input logic [DATA_W-1:0]            dev_req_i,
  input logic [N_CPU-1:0][DATA_W-1:0] mask_i,
  input logic [N_CPU-1:0]             dev_irq_o,
  input logic [N_CPU-1:0]             ipi_o,
  input logic [N_CPU-1:0]             tmr_o
);
  logic [DATA_W-1:0] raw_seen;
  logic [N_CPU-1:0]  irq_model;
  logic              ctrl_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_seen <= '0;
    else         raw_seen <= dev_req_i;
  end

  always_comb
    for (int c = 0; c < N_CPU; c++) irq_model[c] = |(mask_i[c] & raw_seen);

  assign ctrl_wr = req_valid_i & req_write_i & req_full_i &
                   (req_addr_i == ADDR_W'(OFF_CTRL));

  AST_IRQ_MODEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_irq_o == irq_model); // R3

  AST_POST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ((ipi_o & ($past(post_i) & ~$past(iclr_i))) ==
                 ($past(post_i) & ~$past(iclr_i)))); // R4

  AST_ICLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ((ipi_o & $past(iclr_i)) == '0)); // R5

  AST_TCLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ((tmr_o & $past(tclr_i)) == '0)); // R5

  AST_NXM_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && nxm_i) |=> !rsp_err_o); // R6

  AST_EMPTY_CTRL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !nxm_i && post_i == '0 && iclr_i == '0 && tclr_i == '0)
      |=> rsp_err_o); // R6

  AST_PARTIAL_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_full_i) |=> rsp_err_o); // R10

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R12

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R12
endmodule

bind cpu_intr_regs cir_chk #(.N_CPU(N_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_full_i  (req_full_i),
  .req_addr_i  (req_addr_i),
  .post_i      (req_wdata_i[cir_pkg::LANE_POST +: N_CPU]),
  .iclr_i      (req_wdata_i[cir_pkg::LANE_ICLR +: N_CPU]),
  .tclr_i      (req_wdata_i[cir_pkg::LANE_TCLR +: N_CPU]),
  .nxm_i       (req_wdata_i[cir_pkg::BIT_NXM]),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .dev_req_i   (dev_req_i),
  .mask_i      (mask_w),
  .dev_irq_o   (dev_irq_o),
  .ipi_o       (ipi_o),
  .tmr_o       (tmr_o)
);

// File: tb/cpu_intr_regs_tb_top.sv
module cpu_intr_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_full_i = 1'b1;
  logic [4:0]  req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic [1:0]  req_cpu_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_err_o;
  logic [63:0] rsp_rdata_o;
  logic [63:0] dev_req_i = '0;
  logic [3:0]  tmr_tick_i = '0;
  logic [3:0]  dev_irq_o, ipi_o, tmr_o;

  int total = 0;
  int bad = 0;

  localparam logic [63:0] RAW = 64'h00F0_0000_0000_0F0F;

  always #5 clk_i = ~clk_i;

  cpu_intr_regs dut_i (.*);

  typedef struct packed {
    logic [7:0]  req;
    logic        wr;
    logic [4:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{8'd2,  1'b1, 5'd8,  64'hF,          64'h0,     1'b0}, // R2 mask0
    '{8'd2,  1'b0, 5'd8,  64'h0,          64'hF,     1'b0}, // R2
    '{8'd2,  1'b0, 5'd12, 64'h0,          64'hF,     1'b0}, // R2 masked0
    '{8'd2,  1'b1, 5'd9,  64'hF000,       64'h0,     1'b0}, // R2 mask1
    '{8'd2,  1'b0, 5'd13, 64'h0,          64'h0,     1'b0}, // R2 masked1
    '{8'd2,  1'b0, 5'd16, 64'h0,          RAW,       1'b0}, // R2 raw
    '{8'd4,  1'b1, 5'd1,  64'h3000,       64'h0,     1'b0}, // R4 post 0,1
    '{8'd8,  1'b0, 5'd17, 64'h0,          64'h3,     1'b0}, // R8
    '{8'd5,  1'b1, 5'd1,  64'h1100,       64'h0,     1'b0}, // R5 post+clr cpu0
    '{8'd5,  1'b0, 5'd17, 64'h0,          64'h2,     1'b0}, // R5
    '{8'd6,  1'b1, 5'd1,  64'h1000_0000,  64'h0,     1'b0}, // R6 ack only
    '{8'd6,  1'b1, 5'd1,  64'h0,          64'h0,     1'b1}, // R6 empty
    '{8'd7,  1'b0, 5'd1,  64'h0,          64'h0,     1'b0}, // R7 cpu 0
    '{8'd8,  1'b1, 5'd19, 64'hC,          64'h0,     1'b0}, // R8 post 2,3
    '{8'd8,  1'b0, 5'd17, 64'h0,          64'hE,     1'b0}, // R8
    '{8'd8,  1'b1, 5'd17, 64'h6,          64'h0,     1'b0}, // R8 clr 1,2
    '{8'd8,  1'b0, 5'd17, 64'h0,          64'h8,     1'b0}, // R8
    '{8'd9,  1'b0, 5'd0,  64'h0,          64'h0,     1'b0}, // R9
    '{8'd9,  1'b0, 5'd4,  64'h0,          64'h0,     1'b0}, // R9
    '{8'd11, 1'b0, 5'd7,  64'h0,          64'h0,     1'b1}, // R11
    '{8'd11, 1'b1, 5'd13, 64'hFFFF,       64'h0,     1'b1}, // R11 read-only
    '{8'd11, 1'b0, 5'd19, 64'h0,          64'h0,     1'b1}, // R11
    '{8'd11, 1'b0, 5'd24, 64'h0,          64'h0,     1'b1}, // R11
    '{8'd11, 1'b0, 5'd12, 64'h0,          64'hF,     1'b0}  // R11 no effect
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] addr, input logic [63:0] data,
                        input logic full, input logic [1:0] cpu,
                        output logic [63:0] rdata, output logic err, output logic vld);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = addr;
    req_wdata_i = data; req_full_i = full; req_cpu_i = cpu;
    @(posedge clk_i); #1;
    rdata = rsp_rdata_o; err = rsp_err_o; vld = rsp_valid_o;
    @(negedge clk_i);
    req_valid_i = 1'b0; req_write_i = 1'b0; req_full_i = 1'b1;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic er, vl;

    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 dev_irq", 64'(dev_irq_o), 0);
    chk("R1 ipi", 64'(ipi_o), 0);
    chk("R1 tmr", 64'(tmr_o), 0);
    chk("R1 rsp_valid", 64'(rsp_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(0, 5'd8, 0, 1, 0, rd, er, vl);
    chk("R1 mask0", rd, 0);
    access(0, 5'd17, 0, 1, 0, rd, er, vl);
    chk("R1 ipi reg", rd, 0);

    dev_req_i = RAW;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].data, 1, 0, rd, er, vl);
      total++;
      if (rd !== VEC[i].exp || er !== VEC[i].err) begin
        bad++;
        $display("FAIL R%0d vec %0d act=%h/%b exp=%h/%b",
                 VEC[i].req, i, rd, er, VEC[i].exp, VEC[i].err);
      end
    end
    chk("R8 ipi_o after table", 64'(ipi_o), 64'h8);

    // R3 device interrupt
    chk("R3 irq mask0", 64'(dev_irq_o), 64'h1);
    @(negedge clk_i);
    dev_req_i = 64'hF000;
    #2;
    chk("R3 irq before edge", 64'(dev_irq_o), 64'h1);
    @(posedge clk_i); #1;
    chk("R3 irq after raw change", 64'(dev_irq_o), 64'h2);
    access(1, 5'd9, 0, 1, 0, rd, er, vl);
    chk("R3 irq mask1 cleared", 64'(dev_irq_o), 64'h0);
    access(0, 5'd12, 0, 1, 0, rd, er, vl);
    chk("R2 masked0 new raw", rd, 0);

    // R13 timer tick
    @(negedge clk_i);
    tmr_tick_i = 4'b0101;
    @(posedge clk_i); #1;
    chk("R13 tmr_o", 64'(tmr_o), 64'h5);
    @(negedge clk_i);
    tmr_tick_i = '0;
    access(0, 5'd18, 0, 1, 0, rd, er, vl);
    chk("R8 tmr read", rd, 64'h5);
    access(1, 5'd1, 64'h10, 1, 0, rd, er, vl);
    chk("R5 ctrl tmr clr", 64'(tmr_o), 64'h4);
    access(1, 5'd18, 64'h4, 1, 0, rd, er, vl);
    chk("R8 tmr reg clr", 64'(tmr_o), 64'h0);
    // R5 clear beats tick in the same cycle
    @(negedge clk_i);
    tmr_tick_i = 4'b0010;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_full_i = 1'b1;
    req_addr_i = 5'd1; req_wdata_i = 64'h20;
    @(posedge clk_i); #1;
    chk("R5 clr beats tick", 64'(tmr_o), 64'h0);
    @(negedge clk_i);
    tmr_tick_i = '0; req_valid_i = 1'b0; req_write_i = 1'b0;

    // R10 partial writes
    access(1, 5'd10, 64'hF, 0, 0, rd, er, vl);
    chk("R10 partial err", 64'(er), 1);
    access(0, 5'd10, 0, 1, 0, rd, er, vl);
    chk("R10 mask2 unchanged", rd, 0);
    access(1, 5'd1, 64'h4000, 0, 0, rd, er, vl);
    chk("R10 partial ctrl err", 64'(er), 1);
    chk("R10 ipi unchanged", 64'(ipi_o), 64'h8);

    // R11 write to raw
    access(1, 5'd16, 64'h1, 1, 0, rd, er, vl);
    chk("R11 raw write err", 64'(er), 1);

    // R7 cpu id
    access(0, 5'd1, 0, 1, 2, rd, er, vl);
    chk("R7 cpu id", rd, 64'h2);

    // R12 handshake
    chk("R12 ready", 64'(req_ready_o), 1);
    chk("R12 rsp_valid", 64'(vl), 1);
    @(posedge clk_i); #1;
    chk("R12 idle no rsp", 64'(rsp_valid_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule